// File: doc/BRIEF.md
# Load Data Width and Byte-Order Adjuster

This stage sits between a memory read port and a register write port. It takes a 64-bit word whose low bytes hold the data of a load, plus the access size, a byte-reverse request, the little-endian mode of the processor, an optional destination element-width override and a vector/scalar flag. It returns an element already in register byte order, sized to the destination width, placed in its byte lanes of a 64-bit word, together with a byte-enable mask for the register write.

The work happens in a fixed order. First the data is cut to the access size. Then the bytes are reversed within that size when needed. Last, the value is zero-extended to the destination width. If an override would leave the destination narrower than the access, the stage raises an error flag and returns zero data and an empty mask. One registered stage with a valid/ready handshake carries the result.

Top module: `ldadj_stage`

## Requirements
- R1: A request accepted on a rising clock edge (in_valid_i and in_ready_o both high) appears on the outputs with out_valid_o high right after that same edge. out_valid_o falls after an edge where it was high, out_ready_i was high and no new request was accepted.
- R2: While out_valid_o is high and out_ready_i is low, in_ready_o is low, and out_data_o, out_mask_o and out_err_o hold their values. In all other cases in_ready_o is high.
- R3: During reset (rst_ni low) out_valid_o is low and in_ready_o is high.
- R4: The bytes are reversed when brev_i XNOR le_mode_i is 1. With le_mode_i=1 and brev_i=0, or with le_mode_i=0 and brev_i=1, the byte order is kept.
- R5: op_width_i selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. Only that many low bytes of mem_data_i are used, and any reversal acts within them alone. Higher bytes of mem_data_i never reach the output.
- R6: dst_ew_i selects the destination width: 0 is no override, 1 is 8 bits, 2 is 16 bits, 3 is 32 bits. An override at least as wide as the access zero-extends the loaded value to that width and sets no error.
- R7: With no override, a scalar destination (dst_vec_i=0) is 64 bits wide, and a vector destination (dst_vec_i=1) keeps the access width.
- R8: An override narrower than the access sets out_err_o and forces out_data_o and out_mask_o to zero.
- R9: When there is no error, out_mask_o has one bit set for each byte of the destination width. The block of set bits starts at byte (elem_idx_i mod (8 / destination bytes)) times the destination bytes. out_data_o carries the element in those bytes and zero in all other bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Stage can accept a request |
| mem_data_i | input | 64 | Raw memory word, load data in low bytes |
| op_width_i | input | 2 | Access size code |
| brev_i | input | 1 | Byte-reverse load requested |
| le_mode_i | input | 1 | Processor runs little-endian |
| dst_ew_i | input | 2 | Destination width override code |
| dst_vec_i | input | 1 | Destination is a vector element |
| elem_idx_i | input | 3 | Element index of the destination |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| out_data_o | output | 64 | Element placed in its byte lanes |
| out_mask_o | output | 8 | Byte-lane write enables |
| out_err_o | output | 1 | Undefined width combination |

## Verification
The bench goes after the swap polarity, since a design that used plain XOR would reverse little-endian loads and leave byte-reverse loads untouched. It checks short accesses over a word whose upper bytes are non-zero: a design that reversed all eight bytes, or kept the bytes above the access, would put stray bytes into the element. It also covers the split between scalar and vector destinations without an override, overrides equal to and narrower than the access (a wrong compare misses or invents errors), and element indices past the slot count, which show a missing modulo as a shifted mask. A back-pressure sequence offers a second request while the first is held, so an output that changes or a request that gets lost shows up at once.

// File: rtl/ldadj_pkg.sv
package ldadj_pkg;
  // access size codes, value = log2(bytes)
  typedef enum logic [1:0] {OPW_B = 2'd0, OPW_H = 2'd1, OPW_W = 2'd2, OPW_D = 2'd3} opw_e;
  // destination override codes, value - 1 = log2(bytes)
  typedef enum logic [1:0] {EW_DEF = 2'd0, EW_8 = 2'd1, EW_16 = 2'd2, EW_32 = 2'd3} ew_e;
endpackage

// File: rtl/ldadj_swap.sv
module ldadj_swap #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int NW = $clog2(BYTES) + 1,
  localparam int LG_W = $clog2(NW)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LG_W-1:0]   lg_i,
  input  logic              swap_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] plain [NW];
  logic [DATA_W-1:0] rev   [NW];

  for (genvar w = 0; w < NW; w++) begin : g_size
    localparam int NB = 1 << w;
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      if (b < NB) begin : g_in
        assign plain[w][b*8 +: 8] = data_i[b*8 +: 8];
        assign rev[w][b*8 +: 8]   = data_i[(NB-1-b)*8 +: 8];
      end else begin : g_out
        assign plain[w][b*8 +: 8] = 8'h00;
        assign rev[w][b*8 +: 8]   = 8'h00;
      end
    end
  end

  assign data_o = swap_i ? rev[lg_i] : plain[lg_i];
endmodule

// File: rtl/ldadj_width.sv
module ldadj_width
  import ldadj_pkg::*;
(
  input  logic [1:0] op_lg_i,
  input  logic [1:0] ew_i,
  input  logic       vec_i,
  output logic [1:0] dst_lg_o,
  output logic       err_o
);
  always_comb begin
    if (ew_i == EW_DEF) begin
      dst_lg_o = vec_i ? op_lg_i : 2'd3;
      err_o    = 1'b0;
    end else begin
      dst_lg_o = ew_i - 2'd1;
      err_o    = (ew_i - 2'd1) < op_lg_i;
    end
  end
endmodule

// File: rtl/ldadj_lane.sv
module ldadj_lane #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(BYTES),
  localparam int LG_W = $clog2(IDX_W + 1)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [LG_W-1:0]   dst_lg_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              err_i,
  output logic [DATA_W-1:0] data_o,
  output logic [BYTES-1:0]  mask_o
);
  logic [IDX_W-1:0]  slot_m, slot, sh;
  logic [BYTES-1:0]  base_m;
  logic [DATA_W-1:0] lane_bits;

  always_comb begin
    slot_m = IDX_W'((BYTES >> dst_lg_i) - 1);
    slot   = idx_i & slot_m;
    sh     = slot << dst_lg_i;
    for (int b = 0; b < BYTES; b++) begin
      base_m[b]          = b < (1 << dst_lg_i);
      lane_bits[b*8 +: 8] = {8{base_m[b]}};
    end
    if (err_i) begin
      mask_o = '0;
      data_o = '0;
    end else begin
      mask_o = base_m << sh;
      data_o = (val_i & lane_bits) << {sh, 3'b000};
    end
  end
endmodule

// File: rtl/ldadj_stage.sv
module ldadj_stage #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(BYTES),
  localparam int LG_W = $clog2(IDX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [LG_W-1:0]   op_width_i,
  input  logic              brev_i,
  input  logic              le_mode_i,
  input  logic [LG_W-1:0]   dst_ew_i,
  input  logic              dst_vec_i,
  input  logic [IDX_W-1:0]  elem_idx_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [BYTES-1:0]  out_mask_o,
  output logic              out_err_o
);
  logic [DATA_W-1:0] swapped, placed;
  logic [LG_W-1:0]   dst_lg;
  logic              err_c;
  logic [BYTES-1:0]  mask_c;
  logic              accept;

  ldadj_swap #(.DATA_W(DATA_W)) i_swap (
    .data_i (mem_data_i),
    .lg_i   (op_width_i),
    .swap_i (~(brev_i ^ le_mode_i)),
    .data_o (swapped)
  );

  ldadj_width i_width (
    .op_lg_i  (op_width_i),
    .ew_i     (dst_ew_i),
    .vec_i    (dst_vec_i),
    .dst_lg_o (dst_lg),
    .err_o    (err_c)
  );

  ldadj_lane #(.DATA_W(DATA_W)) i_lane (
    .val_i    (swapped),
    .dst_lg_i (dst_lg),
    .idx_i    (elem_idx_i),
    .err_i    (err_c),
    .data_o   (placed),
    .mask_o   (mask_c)
  );

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_mask_o  <= '0;
      out_err_o   <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (accept) begin
        out_data_o <= placed;
        out_mask_o <= mask_c;
        out_err_o  <= err_c;
      end
    end
  end

  // checker view: mask expanded to bit lanes
  logic [DATA_W-1:0] mask_bits;
  always_comb
    for (int b = 0; b < BYTES; b++) mask_bits[b*8 +: 8] = {8{out_mask_o[b]}};

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_mask_o) && $stable(out_err_o));

  assert_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && dst_ew_i != '0 && dst_ew_i > op_width_i |=> !out_err_o);

  assert_default_scalar_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && dst_ew_i == '0 && !dst_vec_i |=> out_mask_o == '1);

  assert_err_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && dst_ew_i != '0 && dst_ew_i <= op_width_i |=> out_err_o);

  assert_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_err_o |-> out_data_o == '0 && out_mask_o == '0);

  assert_lanes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_err_o |-> (out_data_o & ~mask_bits) == '0
      && ($countones(out_mask_o) == 1 || $countones(out_mask_o) == 2
       || $countones(out_mask_o) == 4 || $countones(out_mask_o) == 8));
endmodule

// File: tb/test_ldadj_stage.sv
`timescale 1ns/1ps
module test_ldadj_stage;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] mem_data_i = '0;
  logic [1:0]  op_width_i = '0;
  logic        brev_i = 1'b0;
  logic        le_mode_i = 1'b0;
  logic [1:0]  dst_ew_i = '0;
  logic        dst_vec_i = 1'b0;
  logic [2:0]  elem_idx_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [63:0] out_data_o;
  logic [7:0]  out_mask_o;
  logic        out_err_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  ldadj_stage i_ldadj_stage (.*);

  // returns {err, mask, data}
  function automatic logic [72:0] model(logic [63:0] mem, logic [1:0] op, logic brev,
                                        logic le, logic [1:0] ew, logic vec, logic [2:0] idx);
    logic [63:0] v = '0, d = '0;
    logic [7:0]  m = '0;
    int nb = 1 << op;
    int dlg, db, slot, src;
    bit sw = (brev == le);
    for (int b = 0; b < nb; b++) begin
      src = sw ? nb - 1 - b : b;
      v[b*8 +: 8] = mem[src*8 +: 8];
    end
    dlg = (ew == 0) ? (vec ? int'(op) : 3) : int'(ew) - 1;
    if (ew != 0 && dlg < int'(op)) return {1'b1, 8'h00, 64'h0};
    db = 1 << dlg;
    slot = int'(idx) % (8 / db);
    for (int b = 0; b < db; b++) begin
      m[slot*db + b] = 1'b1;
      d[(slot*db + b)*8 +: 8] = v[b*8 +: 8];
    end
    return {1'b0, m, d};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] mem, logic [1:0] op, logic brev, logic le,
                       logic [1:0] ew, logic vec, logic [2:0] idx);
    mem_data_i = mem; op_width_i = op; brev_i = brev; le_mode_i = le;
    dst_ew_i = ew; dst_vec_i = vec; elem_idx_i = idx; in_valid_i = 1'b1;
  endtask

  task automatic check_out(logic [72:0] e, string req);
    chk(out_valid_o == 1'b1, {req, " R1 valid"}, 64'(out_valid_o), 64'd1);
    chk(out_data_o == e[63:0], {req, " data"}, out_data_o, e[63:0]);
    chk(out_mask_o == e[71:64], {req, " mask"}, 64'(out_mask_o), 64'(e[71:64]));
    chk(out_err_o == e[72], {req, " err"}, 64'(out_err_o), 64'(e[72]));
  endtask

  task automatic xfer(logic [63:0] mem, logic [1:0] op, logic brev, logic le,
                      logic [1:0] ew, logic vec, logic [2:0] idx, string req);
    @(negedge clk_i);
    drive(mem, op, brev, le, ew, vec, idx);
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check_out(model(mem, op, brev, le, ew, vec, idx), req);
  endtask

  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [72:0] ea, eb;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R3 reset valid", 64'(out_valid_o), 64'd0);
    chk(in_ready_o == 1'b1, "R3 reset ready", 64'(in_ready_o), 64'd1);
    rst_ni = 1'b1;

    // directed corner cases
    xfer(PAT, 2'd3, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0, "R4 le no swap");
    xfer(PAT, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 3'd0, "R4 be swap");
    xfer(PAT, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 3'd0, "R4 le brev swap");
    xfer(PAT, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0, "R5 half kept");
    xfer(PAT, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 3'd0, "R5 half swapped");
    xfer(PAT, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 3'd6, "R5 byte vec");
    xfer(PAT, 2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 3'd3, "R7 vec word slot");
    xfer(PAT, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3, "R7 scalar word");
    xfer(PAT, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 3'd5, "R6 byte to half");
    xfer(PAT, 2'd2, 1'b0, 1'b0, 2'd3, 1'b1, 3'd7, "R6 equal width");
    xfer(PAT, 2'd3, 1'b0, 1'b1, 2'd3, 1'b1, 3'd1, "R8 dword to word");
    xfer(PAT, 2'd1, 1'b1, 1'b1, 2'd1, 1'b0, 3'd2, "R8 half to byte");
    xfer(PAT, 2'd0, 1'b1, 1'b0, 2'd1, 1'b1, 3'd7, "R9 byte slot 7");

    // back-pressure
    @(negedge clk_i);
    out_ready_i = 1'b0;
    drive(PAT, 2'd1, 1'b0, 1'b0, 2'd3, 1'b1, 3'd1);
    ea = model(PAT, 2'd1, 1'b0, 1'b0, 2'd3, 1'b1, 3'd1);
    @(posedge clk_i);
    @(negedge clk_i);
    drive(~PAT, 2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 3'd0);
    eb = model(~PAT, 2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 3'd0);
    for (int k = 0; k < 3; k++) begin
      chk(in_ready_o == 1'b0, "R2 ready low", 64'(in_ready_o), 64'd0);
      check_out(ea, "R2 hold");
      @(negedge clk_i);
    end
    out_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check_out(eb, "R2 next accepted");
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 drain", 64'(out_valid_o), 64'd0);

    // random sweep
    for (int n = 0; n < 400; n++) begin
      logic [63:0] rm = {$urandom, $urandom};
      xfer(rm, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), 3'($urandom), "R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule